// File: doc/BRIEF.md
# Dithered Phase-Shifted LED PWM Generator

This block turns per-channel colour settings and per-module brightness settings into one pulse-width-modulated enable bit per LED current channel. Channels come in modules of three (red, green and blue). Each module either uses its own registers or, in bank mode, takes one shared bank brightness and three shared bank colours, one colour for each position within the module. The colour value is multiplied by a brightness scale to give a 12-bit duty. The brightness scale is either linear or follows a logarithmic curve. That duty is carried out as a 512-step PWM period with 3 bits of temporal dithering across a cycle of eight periods.

To spread the load current over the period, the position of a channel inside its module selects how its pulse is placed. The first channel of each module starts its pulse at the start of the period, the second centres its pulse on the midpoint, and the third ends its pulse at the end of the period. A small sequencer with three states (OFF, LOAD, RUN) runs the period counter and the dither-frame counter. Every input is sampled only at the start of a period, so a partial pulse never occurs.

Top module: `dled_pwm`

## Requirements
- R1: When `chip_on` is seen low at a clock edge, the sequencer goes to OFF and every output is 0 from that edge on. From OFF, an edge with `chip_on` high moves to LOAD, where the outputs are still 0. The next edge with `chip_on` high moves to RUN with the period counter at 0 and the dither frame at 0. If `chip_on` is low at that edge, the sequencer goes back to OFF.
- R2: In RUN the period counter steps through 0 to 511 and wraps. The duty in 1/4096 units is `(c' * S) >> 8`, where `c' = c + c[7]`. In linear mode (`log_on` = 0) `S = (b + b[7]) * 16`.
- R3: In logarithmic mode (`log_on` = 1), S is 0 for b = 0 and 4096 for b = 255. For other values of b, S is `((32 + b[4:0]) << b[7:5]) >> 1`.
- R4: The frame counter counts periods modulo 8 from 0. With `dither_on` = 1, the high count of a period is `duty >> 3`, plus 1 when the 3-bit reversal of the frame number is less than `duty[2:0]`.
- R5: With `dither_on` = 0, the high count of a period is exactly `duty >> 3`.
- R6: A channel whose index modulo 3 is 0, and every channel when `phase_on` = 0, is high while counter < w, where w is its high count.
- R7: With `phase_on` = 1, a channel whose index modulo 3 is 1 is high while s <= counter < s + w, where s = (512 - w) >> 1.
- R8: With `phase_on` = 1, a channel whose index modulo 3 is 2 is high while counter >= 512 - w.
- R9: When `bank_mode[m]` = 1, channel k of module m takes its colour from bank colour byte k mod 3 (bits [8j+7:8j] of `bank_color`) and its brightness from `bank_bright`.
- R10: All inputs are sampled only at the edge that enters RUN from LOAD and at the edge where the counter wraps from 511 to 0. A change in the middle of a period has no effect until the next period.
- R11: A colour of 0 or a brightness of 0 keeps a channel low for the whole period. A colour of FFh together with a brightness of FFh keeps it high for all 512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_on | input | 1 | Global enable |
| dither_on | input | 1 | Enables the 3-bit temporal dither |
| log_on | input | 1 | Selects the logarithmic brightness curve |
| phase_on | input | 1 | Enables phase-shifted alignment |
| bank_mode | input | NUM_MOD | Per-module bank-mode select |
| chan_color | input | 8*NUM_CH | Colour byte per channel, channel k at bits [8k+7:8k] |
| mod_bright | input | 8*NUM_MOD | Brightness byte per module |
| bank_color | input | 24 | Three bank colour bytes |
| bank_bright | input | 8 | Bank brightness byte |
| pwm_out | output | NUM_CH | PWM enable per channel |

## Verification
A wrong counter or a wrong sequencer state moves or clips the pulse edges of every channel within the same period. A latch enable that fires at the wrong time makes a pulse width change in mid-period, and this shows at the ports within one period. A wrong frame count or a wrong dither comparison changes the high count by one cycle only in certain frames, so the comparison has to span all eight frames of the dither cycle, about 4096 clocks. The reference model checks every output on every cycle, so an edge that is off by even one cycle is reported in the cycle where it occurs.

// File: rtl/dled_pkg.sv
package dled_pkg;
    localparam int VAL_W   = 8;
    localparam int SCALE_W = 13;

    typedef enum logic [1:0] {SEQ_OFF, SEQ_LOAD, SEQ_RUN} seq_state_e;
    typedef enum logic [1:0] {ALN_LEAD, ALN_MID, ALN_TRAIL} align_e;

    // brightness scale, 0..4096 (4096 = full)
    function automatic logic [SCALE_W-1:0] bright_scale(input logic [VAL_W-1:0] b,
                                                        input logic log_mode);
        logic [SCALE_W-1:0] mant;
        logic [SCALE_W-1:0] sh;
        if (!log_mode) begin
            bright_scale = SCALE_W'({1'b0, b} + 9'(b[7])) << 4;
        end else if (b == '0) begin
            bright_scale = '0;
        end else if (b == '1) begin
            bright_scale = SCALE_W'(4096);
        end else begin
            mant = SCALE_W'(b[4:0]) + SCALE_W'(32);
            sh   = mant << b[7:5];
            bright_scale = sh >> 1;
        end
    endfunction
endpackage

// File: rtl/dled_seq.sv
module dled_seq
    import dled_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int DIT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_on,
    output logic             run,
    output logic             latch_en,
    output logic [DIT_W-1:0] frame_nxt,
    output logic [CNT_W-1:0] cnt
);
    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [DIT_W-1:0] frame_q;
    logic             wrap;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_OFF:  if (chip_on) state_d = SEQ_LOAD;
            SEQ_LOAD: state_d = chip_on ? SEQ_RUN : SEQ_OFF;
            SEQ_RUN:  if (!chip_on) state_d = SEQ_OFF;
            default:  state_d = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run       = (state_q == SEQ_RUN);
        wrap      = (cnt_q == '1);
        latch_en  = chip_on && ((state_q == SEQ_LOAD) || (run && wrap));
        frame_nxt = (state_q == SEQ_LOAD) ? '0 : frame_q + 1'b1;
        cnt       = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            frame_q <= '0;
        end else if (latch_en) begin
            cnt_q   <= '0;
            frame_q <= frame_nxt;
        end else if (run) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dled_duty.sv
module dled_duty
    import dled_pkg::*;
#(
    parameter int CNT_W = 9,
    parameter int DIT_W = 3
) (
    input  logic [VAL_W-1:0] color,
    input  logic [VAL_W-1:0] bright,
    input  logic             log_mode,
    input  logic             dith_en,
    input  logic [DIT_W-1:0] frame,
    output logic [CNT_W:0]   width
);
    localparam int DUTY_W     = CNT_W + DIT_W;
    localparam int DW1        = DUTY_W + 1;
    localparam int PROD_W     = VAL_W + 1 + SCALE_W;
    localparam int PROD_SHIFT = (VAL_W + SCALE_W - 1) - DUTY_W;

    logic [VAL_W:0]     c_ext;
    logic [SCALE_W-1:0] scale;
    logic [PROD_W-1:0]  prod;
    logic [DW1-1:0]     duty;
    logic [DIT_W-1:0]   rev;
    logic               extra;

    always_comb begin
        c_ext = {1'b0, color} + (VAL_W+1)'(color[VAL_W-1]);
        scale = bright_scale(bright, log_mode);
        prod  = PROD_W'(c_ext) * PROD_W'(scale);
        duty  = DW1'(prod >> PROD_SHIFT);
        for (int i = 0; i < DIT_W; i++) rev[i] = frame[DIT_W-1-i];
        extra = dith_en && (rev < duty[DIT_W-1:0]);
        width = duty[DUTY_W:DIT_W] + (CNT_W+1)'(extra);
    end
endmodule

// File: rtl/dled_align.sv
module dled_align
    import dled_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W:0]   width,
    input  align_e           mode,
    output logic             on
);
    localparam int PW = CNT_W + 1;
    localparam logic [PW-1:0] PERIOD = PW'(1 << CNT_W);

    logic [PW-1:0] cnt_e, start, stop;

    always_comb begin
        cnt_e = {1'b0, cnt};
        start = (PERIOD - width) >> 1;
        stop  = start + width;
        unique case (mode)
            ALN_LEAD:  on = cnt_e < width;
            ALN_MID:   on = (cnt_e >= start) && (cnt_e < stop);
            ALN_TRAIL: on = cnt_e >= (PERIOD - width);
            default:   on = 1'b0;
        endcase
    end
endmodule

// File: rtl/dled_pwm.sv
module dled_pwm
    import dled_pkg::*;
#(
    parameter int NUM_MOD = 4,
    parameter int CNT_W   = 9,
    parameter int DIT_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   chip_on,
    input  logic                   dither_on,
    input  logic                   log_on,
    input  logic                   phase_on,
    input  logic [NUM_MOD-1:0]     bank_mode,
    input  logic [8*3*NUM_MOD-1:0] chan_color,
    input  logic [8*NUM_MOD-1:0]   mod_bright,
    input  logic [23:0]            bank_color,
    input  logic [7:0]             bank_bright,
    output logic [3*NUM_MOD-1:0]   pwm_out
);
    localparam int NUM_CH = 3 * NUM_MOD;
    localparam int WW     = CNT_W + 1;

    logic                 run_w, latch_w, phase_q;
    logic [DIT_W-1:0]     frame_w;
    logic [CNT_W-1:0]     cnt_w;
    logic [NUM_CH*WW-1:0] width_flat;

    dled_seq #(.CNT_W(CNT_W), .DIT_W(DIT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .chip_on(chip_on), .run(run_w),
        .latch_en(latch_w), .frame_nxt(frame_w), .cnt(cnt_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase_q <= 1'b0;
        else if (latch_w) phase_q <= phase_on;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int MOD  = ch / 3;
        localparam int COMP = ch % 3;
        logic [7:0]    col_sel, br_sel;
        logic [WW-1:0] w_nxt, w_q;
        align_e        aln;
        logic          on;

        assign col_sel = bank_mode[MOD] ? bank_color[COMP*8 +: 8] : chan_color[ch*8 +: 8];
        assign br_sel  = bank_mode[MOD] ? bank_bright : mod_bright[MOD*8 +: 8];

        dled_duty #(.CNT_W(CNT_W), .DIT_W(DIT_W)) duty_i (
            .color(col_sel), .bright(br_sel), .log_mode(log_on),
            .dith_en(dither_on), .frame(frame_w), .width(w_nxt)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       w_q <= '0;
            else if (latch_w) w_q <= w_nxt;
        end

        always_comb begin
            if (!phase_q || COMP == 0) aln = ALN_LEAD;
            else if (COMP == 1)        aln = ALN_MID;
            else                       aln = ALN_TRAIL;
        end

        dled_align #(.CNT_W(CNT_W)) align_i (
            .cnt(cnt_w), .width(w_q), .mode(aln), .on(on)
        );

        assign pwm_out[ch]            = run_w && on;
        assign width_flat[ch*WW +: WW] = w_q;
    end
endmodule

// File: rtl/dled_pwm_chk.sv
module dled_pwm_chk #(
    parameter int NUM_CH = 12,
    parameter int CNT_W  = 9
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        chip_on,
    input logic [NUM_CH-1:0]           pwm_out,
    input logic                        run,
    input logic [CNT_W-1:0]            cnt,
    input logic                        phase,
    input logic [NUM_CH*(CNT_W+1)-1:0] width_flat
);
    // R1
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!chip_on) |-> (pwm_out == '0));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R10
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && cnt != '0) |-> $stable(width_flat));

    // R6
    lead_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $rose(pwm_out[0])) |-> (cnt == '0));

    // R8
    trail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase && $fell(pwm_out[2])) |-> (cnt == '0));
endmodule

bind dled_pwm dled_pwm_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .chip_on(chip_on), .pwm_out(pwm_out),
    .run(run_w), .cnt(cnt_w), .phase(phase_q), .width_flat(width_flat)
);

// File: tb/dled_pwm_tb.sv
module dled_pwm_tb_top;
    localparam int NM = 4;
    localparam int NC = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic chip_on = 0, dither_on = 0, log_on = 0, phase_on = 0;
    logic [NM-1:0]   bank_mode = '0;
    logic [8*NC-1:0] chan_color;
    logic [8*NM-1:0] mod_bright;
    logic [23:0]     bank_color;
    logic [7:0]      bank_bright = 8'h00;
    logic [NC-1:0]   pwm_out;

    int col [NC];
    int mbr [NM];
    int bcol [3];

    int checks = 0, errors = 0, cycles = 0;
    string cur_tag = "R1";

    // reference model state: 0 off, 1 load, 2 run
    int mstate = 0, mcnt = 0, mframe = 0, mph = 0;
    int mw [NC];

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++) chan_color[i*8 +: 8] = 8'(col[i]);
        for (int i = 0; i < NM; i++) mod_bright[i*8 +: 8] = 8'(mbr[i]);
        for (int i = 0; i < 3; i++)  bank_color[i*8 +: 8] = 8'(bcol[i]);
    end

    dled_pwm #(.NUM_MOD(NM)) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_on(chip_on), .dither_on(dither_on),
        .log_on(log_on), .phase_on(phase_on), .bank_mode(bank_mode),
        .chan_color(chan_color), .mod_bright(mod_bright), .bank_color(bank_color),
        .bank_bright(bank_bright), .pwm_out(pwm_out)
    );

    function automatic int ref_duty(int c, int b, bit lg);
        int cs, bs;
        cs = c + (c >= 128 ? 1 : 0);
        if (!lg)          bs = (b + (b >= 128 ? 1 : 0)) * 16;
        else if (b == 0)  bs = 0;
        else if (b == 255) bs = 4096;
        else              bs = ((32 + b % 32) * (1 << (b / 32))) / 2;
        return (cs * bs) / 256;
    endfunction

    function automatic int ref_width(int ch, int fr);
        int c, b, d, rv;
        c  = bank_mode[ch/3] ? bcol[ch%3] : col[ch];
        b  = bank_mode[ch/3] ? int'(bank_bright) : mbr[ch/3];
        d  = ref_duty(c, b, log_on);
        rv = ((fr & 1) << 2) | (fr & 2) | ((fr >> 2) & 1);
        return d / 8 + ((dither_on && rv < d % 8) ? 1 : 0);
    endfunction

    function automatic bit ref_out(int ch);
        int w, s;
        if (mstate != 2) return 1'b0;
        w = mw[ch];
        if (mph == 0 || ch % 3 == 0) return mcnt < w;
        if (ch % 3 == 1) begin
            s = (512 - w) / 2;
            return (mcnt >= s) && (mcnt < s + w);
        end
        return mcnt >= 512 - w;
    endfunction

    task automatic latch_model(int fr);
        mcnt = 0; mframe = fr; mph = phase_on;
        for (int i = 0; i < NC; i++) mw[i] = ref_width(i, fr);
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mstate = 0; mcnt = 0; mframe = 0; mph = 0;
            for (int i = 0; i < NC; i++) mw[i] = 0;
        end else begin
            case (mstate)
                0: if (chip_on) mstate = 1;
                1: if (chip_on) begin mstate = 2; latch_model(0); end else mstate = 0;
                default: begin
                    if (!chip_on) mstate = 0;
                    else if (mcnt == 511) latch_model((mframe + 1) % 8);
                    else mcnt = mcnt + 1;
                end
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            for (int i = 0; i < NC; i++) begin
                string at;
                bit e;
                e = ref_out(i);
                if (mstate != 2)                    at = "R1";
                else if (mph == 0 || i % 3 == 0)    at = "R6";
                else if (i % 3 == 1)                at = "R7";
                else                                at = "R8";
                checks++;
                if (pwm_out[i] !== e) begin
                    errors++;
                    $display("FAIL %s/%s ch%0d t=%0d got %b exp %b", cur_tag, at, i, cycles, pwm_out[i], e);
                end
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_period();
        @(negedge clk);
        while (!(mstate == 2 && mcnt == 0)) @(negedge clk);
    endtask

    task automatic count_high(int ch, int expv, string tag);
        int n = 0;
        for (int k = 0; k < 512; k++) begin
            if (pwm_out[ch]) n++;
            if (k != 511) @(negedge clk);
        end
        checks++;
        if (n != expv) begin
            errors++;
            $display("FAIL %s ch%0d high count got %0d exp %0d", tag, ch, n, expv);
        end
    endtask

    initial begin
        for (int i = 0; i < NC; i++) col[i] = (i * 37 + 11) % 256;
        for (int i = 0; i < NM; i++) mbr[i] = 60 + i * 55;
        bcol[0] = 255; bcol[1] = 17; bcol[2] = 128;
        wait_cyc(3);
        // R1: reset state
        checks++;
        if (pwm_out !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs got %h exp 0", pwm_out);
        end
        @(negedge clk) rst_n = 1'b1;
        wait_cyc(5);

        // R2 R4 R6 R7 R8: linear, dither and phase on, full dither cycle
        cur_tag = "R4"; dither_on = 1; phase_on = 1;
        @(negedge clk) chip_on = 1;
        wait_cyc(4200);

        // R5: dither off, fixed high count
        cur_tag = "R5"; dither_on = 0; phase_on = 0;
        col[0] = 200; mbr[0] = 100;
        wait_cyc(600);
        sync_period();
        count_high(0, ref_duty(200, 100, 0) / 8, "R5");
        checks++;
        if (ref_duty(200, 100, 0) / 8 != 157) begin
            errors++;
            $display("FAIL R2 duty got %0d exp 157", ref_duty(200, 100, 0) / 8);
        end

        // R3: logarithmic curve, dither and phase on
        cur_tag = "R3"; log_on = 1; dither_on = 1; phase_on = 1;
        mbr[1] = 1; mbr[2] = 200; mbr[3] = 254;
        wait_cyc(4200);

        // R9: bank mode on modules 1 and 3
        cur_tag = "R9"; log_on = 0; bank_mode = 4'b1010; bank_bright = 8'd190;
        wait_cyc(1100);

        // R10: mid-period changes
        cur_tag = "R10"; bank_mode = '0;
        sync_period();
        wait_cyc(200);
        col[3] = 250; mbr[1] = 255; phase_on = 0; dither_on = 0;
        wait_cyc(150);
        col[4] = 3; bank_mode = 4'b0001;
        wait_cyc(900);

        // R11: zero and full
        cur_tag = "R11"; bank_mode = '0; phase_on = 1;
        col[0] = 255; col[1] = 255; col[2] = 255; mbr[0] = 255;
        col[3] = 0; mbr[2] = 0;
        wait_cyc(600);
        sync_period();
        count_high(0, 512, "R11");
        sync_period();
        count_high(3, 0, "R11");
        sync_period();
        count_high(7, 0, "R11");
        sync_period();
        count_high(2, 512, "R11");

        // R1: chip off mid-run, restart
        cur_tag = "R1";
        wait_cyc(100);
        chip_on = 0;
        wait_cyc(20);
        chip_on = 1;
        wait_cyc(1);
        chip_on = 0;
        wait_cyc(5);
        chip_on = 1;
        wait_cyc(1200);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule